// File: doc/BRIEF.md
# One-Hot Population Tally Network

This block counts how many bits of a parameterised input word are set. The count comes out as a bank of mutually exclusive lines, one for each possible count from zero to the full width, rather than as a binary number. A downstream consumer can use the asserted line directly as a select or enable, with no decoder in between.

Internally the network is a chain of identical single-bit stages. Each stage carries a one-hot vector. A clear input bit lets the vector pass on unchanged. A set input bit shifts it up by one position. The first stage is seeded with its lowest line high, and every position a stage cannot source is driven low, so no output is ever left undetermined. A separate checker watches the output bank and raises an error line whenever the bank is not exactly one-hot.

The block is purely combinational and has no clock or reset. Its pins carry a count rather than a data stream, so they are plain signals with no handshake.

Top module: `tally_onehot_net`

## Requirements
- R1: With NUM_IN input bits there are NUM_IN+1 count lines; line k (bit k of `count_oh`) is 1 exactly when k of the input bits are 1.
- R2: For every input pattern exactly one count line is 1.
- R3: An input bit that is 0 leaves the count unchanged. Clearing a bit in any position lowers the asserted line by exactly one, and the position of a set bit has no effect on which line is asserted.
- R4: An input bit that is 1 moves the asserted line up by one position. A pattern with a single set bit, in any position, asserts line 1.
- R5: The chain is seeded on line 0, so the all-zero input asserts line 0 and no other line.
- R6: No line floats. Line 0 is driven to 0 whenever any input bit is 1, and the all-ones input asserts line NUM_IN and no other line.
- R7: `onehot_err` is 1 only when `count_oh` is not exactly one-hot, and it therefore stays 0 for a correct network.
- R8: Restricted to the two lowest input bits with all others 0, input 00 asserts line 0, 01 and 10 assert line 1, and 11 asserts line 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_bits | input | NUM_IN | Bits to be counted |
| count_oh | output | NUM_IN+1 | One-hot count; bit k high when k inputs are set |
| onehot_err | output | 1 | High when `count_oh` is not exactly one-hot |

## Verification
The bench builds the block with NUM_IN = 8, which gives nine count lines and 256 input patterns. At this size every pattern can be applied, so the one-hot property and the match between the asserted index and a reference population count are checked over the whole input space, not over a sample. The sweep covers the seed case, the all-ones case, every single-bit pattern, the two-bit slice and every mixed pattern of set and clear stages.

// File: rtl/tally_pkg.sv
package tally_pkg;
  // Default number of counted input bits.
  localparam int unsigned DEFAULT_INPUTS = 8;

  // Width of an index that can name any of n+1 count lines.
  function automatic int unsigned line_idx_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < (n + 1)) w++;
    return w;
  endfunction
endpackage

// File: rtl/tally_stage.sv
module tally_stage #(
  parameter int unsigned LINES = 9
) (
  input  logic [LINES-1:0] vec_in,
  input  logic             step,
  output logic [LINES-1:0] vec_out
);
  // Position 0 has no diagonal source, so it is forced low on a step.
  assign vec_out[0] = step ? 1'b0 : vec_in[0];

  for (genvar k = 1; k < LINES; k++) begin : g_pos
    // A clear step takes the straight path; a set step takes the diagonal.
    assign vec_out[k] = step ? vec_in[k-1] : vec_in[k];
  end
endmodule

// File: rtl/tally_chain.sv
module tally_chain #(
  parameter int unsigned NUM_IN = 8,
  localparam int unsigned LINES = NUM_IN + 1
) (
  input  logic [NUM_IN-1:0] bits,
  output logic [LINES-1:0]  tally
);
  logic [LINES-1:0] link [0:NUM_IN];

  // The seed vector holds a 1 on line 0 only.
  assign link[0] = {{(LINES-1){1'b0}}, 1'b1};

  for (genvar s = 0; s < NUM_IN; s++) begin : g_stage
    tally_stage #(.LINES(LINES)) stage_i (
      .vec_in (link[s]),
      .step   (bits[s]),
      .vec_out(link[s+1])
    );
  end

  assign tally = link[NUM_IN];
endmodule

// File: rtl/onehot_watch.sv
module onehot_watch #(
  parameter int unsigned WIDTH = 9
) (
  input  logic [WIDTH-1:0] vec,
  output logic             bad
);
  logic any_set;
  logic many_set;

  // Scan the vector and note whether one bit, or more than one, is set.
  always_comb begin
    any_set  = 1'b0;
    many_set = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) begin
        if (any_set) many_set = 1'b1;
        any_set = 1'b1;
      end
    end
    bad = many_set | ~any_set;
  end
endmodule

// File: rtl/tally_onehot_net.sv
module tally_onehot_net #(
  parameter int unsigned NUM_IN = tally_pkg::DEFAULT_INPUTS
) (
  input  logic [NUM_IN-1:0] in_bits,
  output logic [NUM_IN:0]   count_oh,
  output logic              onehot_err
);
  localparam int unsigned LINES = NUM_IN + 1;
  localparam int unsigned IW    = tally_pkg::line_idx_width(NUM_IN);

  tally_chain #(.NUM_IN(NUM_IN)) chain_i (
    .bits (in_bits),
    .tally(count_oh)
  );

  onehot_watch #(.WIDTH(LINES)) watch_i (
    .vec(count_oh),
    .bad(onehot_err)
  );

  // Reference count built by adding, independent of the steering chain.
  logic [IW-1:0] ref_cnt;
  always_comb begin
    ref_cnt = '0;
    for (int i = 0; i < NUM_IN; i++) ref_cnt = ref_cnt + IW'(in_bits[i]);
  end

  always_comb begin
    p_onehot_r2: assert ($countones(count_oh) == 1)
      else $error("count lines not one-hot: %b", count_oh);
    p_index_r1: assert (count_oh[ref_cnt] == 1'b1)
      else $error("line %0d low for input %b", ref_cnt, in_bits);
    p_err_quiet_r7: assert (onehot_err == 1'b0)
      else $error("checker flagged %b", count_oh);
    p_zero_line_r6: assert ((in_bits == '0) || (count_oh[0] == 1'b0))
      else $error("line 0 high with input %b", in_bits);
  end
endmodule

// File: tb/tally_onehot_net_tb_top.sv
module tally_onehot_net_tb_top;
  localparam int unsigned N = 8;

  logic         clk = 1'b0;
  logic [N-1:0] in_bits = '0;
  logic [N:0]   count_oh;
  logic         onehot_err;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  int unsigned cycles = 0;
  bit          ended  = 1'b0;

  int unsigned exp_q [$];
  int unsigned pat_q [$];

  always #4 clk = ~clk;

  tally_onehot_net #(.NUM_IN(N)) dut_i (
    .in_bits   (in_bits),
    .count_oh  (count_oh),
    .onehot_err(onehot_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned popcnt(input int unsigned p);
    int unsigned c = 0;
    for (int i = 0; i < N; i++) if (p[i]) c++;
    return c;
  endfunction

  // Driver: applies one pattern per cycle and queues its expected count.
  task automatic drive(input int unsigned p);
    @(posedge clk);
    in_bits = p[N-1:0];
    exp_q.push_back(popcnt(p));
    pat_q.push_back(p);
  endtask

  // Monitor: compares the settled outputs half a cycle later.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int unsigned e;
      int unsigned p;
      string tag;
      logic [N:0] want;
      e = exp_q.pop_front();
      p = pat_q.pop_front();
      want = '0;
      want[e] = 1'b1;
      if (p == 0)                       tag = "R5";
      else if (p == (1 << N) - 1)       tag = "R6";
      else if (e == 1)                  tag = "R4";
      else if ((p >> 2) == 0)           tag = "R8";
      else                              tag = "R3";
      check(count_oh == want, tag, "count vector", count_oh, want);
      check(count_oh[e] == 1'b1, "R1", "expected line", count_oh[e], 1);
      check($countones(count_oh) == 1, "R2", "lines high",
            $countones(count_oh), 1);
      check(onehot_err == 1'b0, "R7", "checker flag", onehot_err, 0);
      if (p != 0)
        check(count_oh[0] == 1'b0, "R6", "line 0 driven low", count_oh[0], 0);
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Watchdog.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    // Quiescent state before the sweep: all-zero input on line 0 (R5).
    #2;
    check(count_oh == 9'b1, "R5", "idle vector", count_oh, 1);
    // Two-bit slice first (R8), then the full exhaustive sweep (R1, R2).
    drive(0); drive(1); drive(2); drive(3);
    for (int p = 0; p < (1 << N); p++) drive(p);
    // Clearing one set bit lowers the count by one (R3).
    drive(8'hFF); drive(8'hF7); drive(8'h77); drive(8'h76);
    @(posedge clk);
    @(posedge clk);
    finish_run();
  end
endmodule